// File: doc/BRIEF.md
# Low-Power Compare Timer Core

This block is a 16-bit up-counter that compares its count against a programmable limit and raises a sticky hit flag, an interrupt and a hardware trigger when the limit is reached. Software reaches it through four 32-bit word registers: control/status at byte offset 0x0, scale at 0x4, limit at 0x8 and count at 0xC. On the bus these are selected by a two-bit word index (0 to 3).

The counter advances only on cycles where the one-cycle `tick` strobe from an external prescaler is high. In time mode every tick is one count. In pulse mode the tick acts as a sample strobe for one of four pulse inputs, and a count is taken on each sampled edge of the chosen polarity. The scale register is not interpreted by the core. It is handed to the prescaler on `scale_cfg`.

A hit is a tick that advances the counter while the count equals the limit. On a hit the counter either returns to zero or keeps running, depending on the reset-behaviour bit. When it keeps running it wraps from 0xFFFF to 0.

Top module: `lpct_core`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `trig` and `scale_cfg` are zero.
- R2: With the enable (control bit 0) set and the mode (control bit 1) at 0, each cycle with `tick` high adds one to the count (count register, word 3, bits 15:0), and cycles without `tick` leave it unchanged.
- R3: With control bit 2 at 0, a counting tick at count equal to limit (word 2, bits 15:0) sets the hit flag (control bit 7) and returns the count to 0 on the same edge.
- R4: With control bit 2 at 1, a hit sets the flag, and the count goes on to limit+1. From 0xFFFF the count wraps to 0.
- R5: A control write with bit 7 at 1 clears the hit flag. A control write with bit 7 at 0 leaves the flag as it is.
- R6: `irq` is high exactly while the interrupt enable (control bit 6) and the hit flag are both set.
- R7: `trig` rises on a hit and falls on the next counting tick. When the limit is 0 it stays high until the timer is disabled.
- R8: While the enable is clear, the count, the hit flag, `trig` and the pulse edge history are held at their reset values.
- R9: In pulse mode (control bit 1 at 1), the input chosen by control bits 5:4 is sampled on each tick. The count advances on a tick whose sample is 1 after a previous sample of 0, with the input inverted first when the polarity bit (control bit 3) is 1. The history is taken as 1 on enable, and unselected inputs have no effect.
- R10: While the enable is set, writes to control bits 5:1 and to the scale register (word 1, bits 6:0) are ignored. When the timer is disabled, those writes take effect, and `scale_cfg` follows the scale register.
- R11: Writes to the count register have no effect. Unused upper bits of every register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 16 | Write data (register bits 15:0) |
| bus_rdata | output | 32 | Read data, combinational, zero when no access |
| tick | input | 1 | One-cycle advance strobe from the prescaler |
| pulse_in | input | 4 | Pulse-mode inputs, synchronous to clk |
| irq | output | 1 | Interrupt request |
| trig | output | 1 | Hardware trigger |
| scale_cfg | output | 7 | Scale register contents for the prescaler |

## Verification
A register write or a tick takes effect on the rising edge where it is presented, and reads are combinational. The bench therefore drives each stimulus at a falling edge and reads the result at the next falling edge. Disabling the timer is the exception: the clear happens on the edge after the disabling write, so the bench waits two cycles before checking the cleared state. The count, the flag and `trig` are all updated on the same edge as a hit, so all three are checked together after one tick. For the wrap case, `tick` is held high for many consecutive cycles, and the count is read back only at the boundary values.

// File: rtl/lpct_pkg.sv
package lpct_pkg;
   // control/status bit positions (software decodes these)
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_MODE = 1;
   localparam int unsigned CB_FREE = 2;
   localparam int unsigned CB_POL  = 3;
   localparam int unsigned CB_SEL  = 4;
   localparam int unsigned CB_IE   = 6;
   localparam int unsigned CB_FLAG = 7;

   typedef enum logic [1:0] {
      RS_CTRL  = 2'd0,
      RS_SCALE = 2'd1,
      RS_LIMIT = 2'd2,
      RS_COUNT = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [1:0] pin_sel;
      logic       pol_low;
      logic       free_run;
      logic       pulse_mode;
   } mode_cfg_t;
endpackage

// File: rtl/lpct_regs.sv
module lpct_regs
   import lpct_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned SCALE_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [1:0]         bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]   count_in,
   input  logic               flag_in,
   output logic               run_en,
   output mode_cfg_t          cfg,
   output logic               irq_en,
   output logic [CNT_W-1:0]   limit,
   output logic [SCALE_W-1:0] scale,
   output logic               flag_clr
);
   reg_sel_e sel;
   logic     wr;

   assign sel      = reg_sel_e'(bus_addr);
   assign wr       = bus_valid && bus_write;
   assign flag_clr = wr && (sel == RS_CTRL) && bus_wdata[CB_FLAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en <= 1'b0;
         cfg    <= '0;
         irq_en <= 1'b0;
         limit  <= '0;
         scale  <= '0;
      end else if (wr) begin
         unique case (sel)
            RS_CTRL: begin
               run_en <= bus_wdata[CB_EN];
               irq_en <= bus_wdata[CB_IE];
               if (!run_en) begin
                  cfg.pulse_mode <= bus_wdata[CB_MODE];
                  cfg.free_run   <= bus_wdata[CB_FREE];
                  cfg.pol_low    <= bus_wdata[CB_POL];
                  cfg.pin_sel    <= bus_wdata[CB_SEL+1:CB_SEL];
               end
            end
            RS_SCALE: if (!run_en) scale <= bus_wdata[SCALE_W-1:0];
            RS_LIMIT: limit <= bus_wdata;
            RS_COUNT: ; // counter is read-only
            default:  ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_valid && !bus_write) begin
         unique case (sel)
            RS_CTRL: begin
               bus_rdata[CB_EN]              = run_en;
               bus_rdata[CB_MODE]            = cfg.pulse_mode;
               bus_rdata[CB_FREE]            = cfg.free_run;
               bus_rdata[CB_POL]             = cfg.pol_low;
               bus_rdata[CB_SEL+1:CB_SEL]    = cfg.pin_sel;
               bus_rdata[CB_IE]              = irq_en;
               bus_rdata[CB_FLAG]            = flag_in;
            end
            RS_SCALE: bus_rdata[SCALE_W-1:0] = scale;
            RS_LIMIT: bus_rdata[CNT_W-1:0]   = limit;
            RS_COUNT: bus_rdata[CNT_W-1:0]   = count_in;
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/lpct_event.sv
module lpct_event #(
   parameter int unsigned NUM_PINS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_en,
   input  logic                pulse_mode,
   input  logic                pol_low,
   input  logic [1:0]          pin_sel,
   input  logic                tick,
   input  logic [NUM_PINS-1:0] pins,
   output logic                adv
);
   logic raw;
   logic lvl;
   logic prev_q;

   generate
      if (NUM_PINS == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^pin_sel;
         assign raw = pins[0] & ~(unused_sel & 1'b0);
      end else begin : g_mux
         always_comb begin
            raw = 1'b0;
            for (int i = 0; i < NUM_PINS; i++) begin
               if (pin_sel == i[1:0]) raw = pins[i];
            end
         end
      end
   endgenerate

   assign lvl = raw ^ pol_low;

   // history starts at the active level, so a fresh edge is required
   always_ff @(posedge clk) begin
      if (!rst_n || !run_en) prev_q <= 1'b1;
      else if (tick && pulse_mode) prev_q <= lvl;
   end

   assign adv = run_en && tick && (!pulse_mode || (lvl && !prev_q));
endmodule

// File: rtl/lpct_count.sv
module lpct_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             free_run,
   input  logic             adv,
   input  logic [CNT_W-1:0] limit,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             trig
);
   logic hit;
   logic limit_zero;

   assign hit        = adv && (count == limit);
   assign limit_zero = (limit == '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !run_en) begin
         count <= '0;
         flag  <= 1'b0;
         trig  <= 1'b0;
      end else begin
         if (adv) begin
            if (hit && !free_run) count <= '0;
            else                  count <= count + 1'b1;
         end
         if (hit)           flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
         if (hit)                      trig <= 1'b1;
         else if (adv && !limit_zero)  trig <= 1'b0;
      end
   end
endmodule

// File: rtl/lpct_core.sv
module lpct_core
   import lpct_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SCALE_W  = 7,
   parameter int unsigned NUM_PINS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [1:0]          bus_addr,
   input  logic [CNT_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                tick,
   input  logic [NUM_PINS-1:0] pulse_in,
   output logic                irq,
   output logic                trig,
   output logic [SCALE_W-1:0]  scale_cfg
);
   localparam int unsigned CTRL_W = CB_FLAG + 1;

   generate
      if (CNT_W < CTRL_W || CNT_W > DATA_W) begin : g_bad_cnt
         $error("lpct_core: CNT_W must lie between the control width and DATA_W");
      end
      if (SCALE_W == 0 || SCALE_W > CNT_W) begin : g_bad_scale
         $error("lpct_core: SCALE_W must be 1..CNT_W");
      end
      if (NUM_PINS < 1 || NUM_PINS > 4) begin : g_bad_pins
         $error("lpct_core: NUM_PINS must be 1..4");
      end
   endgenerate

   logic             run_en;
   mode_cfg_t        cfg;
   logic             irq_en;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] count;
   logic             flag;
   logic             flag_clr;
   logic             adv;

   lpct_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_in(count), .flag_in(flag),
      .run_en(run_en), .cfg(cfg), .irq_en(irq_en), .limit(limit),
      .scale(scale_cfg), .flag_clr(flag_clr)
   );

   lpct_event #(.NUM_PINS(NUM_PINS)) u_event (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .pulse_mode(cfg.pulse_mode), .pol_low(cfg.pol_low), .pin_sel(cfg.pin_sel),
      .tick(tick), .pins(pulse_in), .adv(adv)
   );

   lpct_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .free_run(cfg.free_run),
      .adv(adv), .limit(limit), .flag_clr(flag_clr),
      .count(count), .flag(flag), .trig(trig)
   );

   assign irq = irq_en && flag;
endmodule

// File: rtl/lpct_checker.sv
module lpct_checker
   import lpct_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input mode_cfg_t        cfg,
   input logic             adv,
   input logic             tick,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] limit,
   input logic             flag,
   input logic             trig
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !tick) |=> (!run_en || count == $past(count)));

   p_hit_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && adv && !cfg.free_run && count == limit) |=> (count == '0 && flag));

   p_free_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && adv && cfg.free_run) |=> (count == CNT_W'($past(count) + 1'b1)));

   p_trig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && trig && !adv) |=> trig);

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en) |=> (count == '0 && !flag && !trig));

   p_cfg_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(cfg));
endmodule

bind lpct_core lpct_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg(cfg), .adv(adv),
   .tick(tick), .count(count), .limit(limit), .flag(flag), .trig(trig)
);

// File: tb/lpct_core_test.sv
module lpct_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick = 1'b0;
   logic [3:0]  pulse_in = '0;
   logic        irq;
   logic        trig;
   logic [6:0]  scale_cfg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lpct_core uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick(tick), .pulse_in(pulse_in), .irq(irq), .trig(trig), .scale_cfg(scale_cfg)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic disable_timer();
      wr(2'd0, 16'h0000);
      idle(2);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int i = 0; i < 4; i++) begin
         rd(i[1:0], d);
         check("R1 register after reset", d, 32'h0);
      end
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 trig", {31'b0, trig}, 32'h0);
      check("R1 scale_cfg", {25'b0, scale_cfg}, 32'h0);
   endtask

   task automatic t_time_clear();
      logic [31:0] d;
      wr(2'd2, 16'd3);
      wr(2'd0, 16'h0001);
      ticks(1);
      rd(2'd3, d); check("R2 one tick", d, 32'd1);
      ticks(2);
      rd(2'd3, d); check("R2 three ticks", d, 32'd3);
      idle(5);
      rd(2'd3, d); check("R2 no tick hold", d, 32'd3);
      ticks(1);
      rd(2'd3, d); check("R3 clear on hit", d, 32'd0);
      rd(2'd0, d); check("R3 flag set", d, 32'h81);
      check("R7 trig on hit", {31'b0, trig}, 32'h1);
      ticks(1);
      rd(2'd3, d); check("R3 count after clear", d, 32'd1);
      check("R7 trig falls", {31'b0, trig}, 32'h0);
      wr(2'd0, 16'h0001);
      rd(2'd0, d); check("R5 write 0 keeps flag", d, 32'h81);
      wr(2'd0, 16'h0081);
      rd(2'd0, d); check("R5 write 1 clears flag", d, 32'h01);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(2'd0, 16'h0041);
      check("R6 irq no flag", {31'b0, irq}, 32'h0);
      ticks(3);
      rd(2'd0, d); check("R6 flag", d, 32'hC1);
      check("R6 irq on", {31'b0, irq}, 32'h1);
      wr(2'd0, 16'h0081);
      rd(2'd0, d); check("R6 flag cleared ie off", d, 32'h01);
      check("R6 irq off", {31'b0, irq}, 32'h0);
      ticks(1);
      ticks(2);
      check("R6 irq masked", {31'b0, irq}, 32'h0);
      disable_timer();
      rd(2'd3, d); check("R8 count cleared", d, 32'd0);
      rd(2'd0, d); check("R8 flag cleared", d, 32'h0);
      check("R8 trig cleared", {31'b0, trig}, 32'h0);
   endtask

   task automatic t_free();
      logic [31:0] d;
      wr(2'd2, 16'd2);
      wr(2'd0, 16'h0005);
      ticks(3);
      rd(2'd3, d); check("R4 runs past limit", d, 32'd3);
      rd(2'd0, d); check("R4 flag", d, 32'h85);
      check("R7 trig free hit", {31'b0, trig}, 32'h1);
      ticks(1);
      check("R7 trig next tick", {31'b0, trig}, 32'h0);
      ticks(65531);
      rd(2'd3, d); check("R4 top value", d, 32'hFFFF);
      ticks(1);
      rd(2'd3, d); check("R4 wrap", d, 32'h0);
      disable_timer();
   endtask

   task automatic t_zero_limit();
      logic [31:0] d;
      wr(2'd2, 16'd0);
      wr(2'd0, 16'h0005);
      ticks(1);
      check("R7 zero limit trig", {31'b0, trig}, 32'h1);
      ticks(3);
      rd(2'd3, d); check("R7 zero limit count", d, 32'd4);
      check("R7 zero limit trig held", {31'b0, trig}, 32'h1);
      disable_timer();
      check("R7 trig drops on disable", {31'b0, trig}, 32'h0);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      wr(2'd0, 16'h0001);
      wr(2'd0, 16'h003F);
      rd(2'd0, d); check("R10 ctrl bits locked", d, 32'h01);
      wr(2'd1, 16'h0055);
      rd(2'd1, d); check("R10 scale locked", d, 32'h0);
      check("R10 scale_cfg locked", {25'b0, scale_cfg}, 32'h0);
      wr(2'd3, 16'h1234);
      rd(2'd3, d); check("R11 count write ignored", d, 32'h0);
      disable_timer();
      wr(2'd1, 16'hFFFF);
      rd(2'd1, d); check("R11 scale upper zero", d, 32'h7F);
      check("R10 scale_cfg follows", {25'b0, scale_cfg}, 32'h7F);
      wr(2'd2, 16'hFFFF);
      rd(2'd2, d); check("R11 limit read", d, 32'hFFFF);
   endtask

   task automatic t_pulse();
      logic [31:0] d;
      pulse_in = 4'b0000;
      wr(2'd0, 16'h0023);
      rd(2'd0, d); check("R9 pulse cfg", d, 32'h23);
      ticks(1);
      pulse_in[2] = 1'b1;
      ticks(1);
      rd(2'd3, d); check("R9 rising counted", d, 32'd1);
      ticks(1);
      pulse_in[0] = 1'b1; pulse_in[3] = 1'b1;
      ticks(1);
      pulse_in[0] = 1'b0; pulse_in[3] = 1'b0;
      ticks(1);
      rd(2'd3, d); check("R9 level and other pins ignored", d, 32'd1);
      pulse_in[2] = 1'b0;
      ticks(1);
      pulse_in[2] = 1'b1;
      ticks(1);
      rd(2'd3, d); check("R9 second rising", d, 32'd2);
      pulse_in[2] = 1'b0; idle(1);
      pulse_in[2] = 1'b1; idle(1);
      rd(2'd3, d); check("R9 edge without tick ignored", d, 32'd2);
      disable_timer();
      wr(2'd0, 16'h002B);
      ticks(1);
      pulse_in[2] = 1'b0;
      ticks(1);
      rd(2'd3, d); check("R9 falling counted", d, 32'd1);
      pulse_in[2] = 1'b1;
      ticks(1);
      rd(2'd3, d); check("R9 rising ignored when inverted", d, 32'd1);
      disable_timer();
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_time_clear();
      t_irq();
      t_free();
      t_zero_limit();
      t_lock();
      t_pulse();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule